// File: doc/BRIEF.md
# Offset Calibration and Output Formatter

This block sits between the raw converter output and the sample FIFO. It takes 12-bit two's-complement conversion results with a valid strobe. It removes a self-measured offset from each result and presents the corrected value in one of two codings. The coding is chosen per sample.

A one-cycle pulse on `cal_start_i` starts a calibration. The block raises `force_zero_o`, which tells the front end to short its inputs. The next valid result is taken as the offset and stored. That result is not passed downstream, and `force_zero_o` falls again. Every later sample has the stored offset subtracted, with saturation to the 12-bit range. A synchronous soft reset clears the offset and abandons a calibration that is in progress.

Top module: `ocf_top`

## Requirements
- R1: After reset (`rst_ni` low), `out_valid_o` and `force_zero_o` are 0 and the stored offset is 0. Samples then pass through unchanged.
- R2: A `cal_start_i` pulse while not calibrating raises `force_zero_o` from the next cycle on.
- R3: The first `raw_valid_i` sample taken while `force_zero_o` is 1 is stored as the offset. No output is produced for it, and `force_zero_o` is 0 in the following cycle.
- R4: Each later sample produces raw minus offset, computed in two's complement.
- R5: The difference saturates: below -2048 it gives 0x800, and above +2047 it gives 0x7FF.
- R6: With `fmt_bin_i` = 0, the output is the two's-complement difference. With `fmt_bin_i` = 1, bit 11 of that value is inverted to give offset binary. `fmt_bin_i` is sampled together with the sample.
- R7: `out_valid_o` follows a non-calibration `raw_valid_i` exactly one cycle later, and each sample gives exactly one output.
- R8: `soft_rst_i` clears the offset to 0 and ends calibration. A sample presented in the same cycle as `soft_rst_i` produces no output.
- R9: A `cal_start_i` pulse during calibration is ignored. The next sample is still the one captured, and `force_zero_o` then drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| soft_rst_i | input | 1 | Synchronous clear of the offset and the calibration state |
| cal_start_i | input | 1 | Calibration request pulse |
| fmt_bin_i | input | 1 | Output coding: 0 = two's complement, 1 = offset binary |
| raw_valid_i | input | 1 | Raw sample strobe |
| raw_data_i | input | 12 | Raw sample, two's complement |
| force_zero_o | output | 1 | Tells the front end to force its inputs to zero |
| out_valid_o | output | 1 | Corrected sample strobe |
| out_data_o | output | 12 | Corrected, formatted sample |

## Verification
The hardest situations to create are saturation at both rails and overlapping control events. Saturation only occurs when a large offset meets a sample of the opposite extreme. The stimulus therefore first stores a positive offset and then a negative one. It then sends the most negative and most positive codes, in both codings. A repeated calibration request during capture, a soft reset during calibration, and a soft reset in the same cycle as a sample are each driven on purpose. After each, the force-zero line and the valid strobe are checked.

// File: rtl/ocf_pkg.sv
package ocf_pkg;
  typedef enum logic {ST_RUN = 1'b0, ST_CAL = 1'b1} cal_state_e;
endpackage

// File: rtl/ocf_cal_ctrl.sv
module ocf_cal_ctrl
  import ocf_pkg::*;
#(
  parameter int DW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          soft_rst_i,
  input  logic          cal_start_i,
  input  logic          raw_valid_i,
  input  logic [DW-1:0] raw_data_i,
  output logic          force_zero_o,
  output logic          capture_o,
  output logic [DW-1:0] offset_o
);
  cal_state_e    state_q;
  logic [DW-1:0] offset_q;

  assign force_zero_o = (state_q == ST_CAL);
  assign capture_o    = force_zero_o && raw_valid_i && !soft_rst_i;
  assign offset_o     = offset_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_RUN;
      offset_q <= '0;
    end else if (soft_rst_i) begin
      state_q  <= ST_RUN;
      offset_q <= '0;
    end else begin
      unique case (state_q)
        ST_RUN: if (cal_start_i) state_q <= ST_CAL;
        ST_CAL: if (raw_valid_i) begin
          offset_q <= raw_data_i;
          state_q  <= ST_RUN;
        end
        default: state_q <= ST_RUN;
      endcase
    end
  end

  p_force_rise_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !force_zero_o && cal_start_i && !soft_rst_i |=> force_zero_o);

  p_restart_ignored_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_zero_o && cal_start_i && !raw_valid_i && !soft_rst_i |=> force_zero_o);

  p_soft_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> !force_zero_o && offset_o == '0);
endmodule

// File: rtl/ocf_sat_sub.sv
module ocf_sat_sub #(
  parameter int DW = 12
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic [DW-1:0] diff_o
);
  localparam logic signed [DW:0] MAX_W = {2'b00, {(DW-1){1'b1}}};
  localparam logic signed [DW:0] MIN_W = {2'b11, {(DW-1){1'b0}}};

  logic signed [DW:0] wide;

  always_comb begin
    wide = $signed({a_i[DW-1], a_i}) - $signed({b_i[DW-1], b_i});
    if (wide > MAX_W)      diff_o = {1'b0, {(DW-1){1'b1}}};
    else if (wide < MIN_W) diff_o = {1'b1, {(DW-1){1'b0}}};
    else                   diff_o = wide[DW-1:0];
  end
endmodule

// File: rtl/ocf_fmt.sv
module ocf_fmt #(
  parameter int DW = 12
) (
  input  logic          bin_i,
  input  logic [DW-1:0] val_i,
  output logic [DW-1:0] val_o
);
  // offset binary: flip the sign bit
  assign val_o = {val_i[DW-1] ^ bin_i, val_i[DW-2:0]};
endmodule

// File: rtl/ocf_top.sv
module ocf_top #(
  parameter int DATA_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic              cal_start_i,
  input  logic              fmt_bin_i,
  input  logic              raw_valid_i,
  input  logic [DATA_W-1:0] raw_data_i,
  output logic              force_zero_o,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_data_o
);
  logic              capture;
  logic [DATA_W-1:0] offset;
  logic [DATA_W-1:0] diff;
  logic [DATA_W-1:0] coded;
  logic              valid_q;
  logic [DATA_W-1:0] data_q;

  ocf_cal_ctrl #(.DW(DATA_W)) u_cal (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .soft_rst_i   (soft_rst_i),
    .cal_start_i  (cal_start_i),
    .raw_valid_i  (raw_valid_i),
    .raw_data_i   (raw_data_i),
    .force_zero_o (force_zero_o),
    .capture_o    (capture),
    .offset_o     (offset)
  );

  ocf_sat_sub #(.DW(DATA_W)) u_sub (
    .a_i    (raw_data_i),
    .b_i    (offset),
    .diff_o (diff)
  );

  ocf_fmt #(.DW(DATA_W)) u_fmt (
    .bin_i (fmt_bin_i),
    .val_i (diff),
    .val_o (coded)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= raw_valid_i && !capture && !soft_rst_i;
      if (raw_valid_i) data_q <= coded;
    end
  end

  assign out_valid_o = valid_q;
  assign out_data_o  = data_q;

  p_latency_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    raw_valid_i && !force_zero_o && !soft_rst_i |=> out_valid_o);

  p_no_stray_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !raw_valid_i |=> !out_valid_o);

  p_cal_swallow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_zero_o && raw_valid_i && !soft_rst_i |=> !force_zero_o && !out_valid_o);

  p_soft_drop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> !out_valid_o);
endmodule

// File: tb/ocf_top_test.sv
module ocf_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_rst = 1'b0;
  logic        cal_start = 1'b0;
  logic        fmt_bin = 1'b0;
  logic        raw_valid = 1'b0;
  logic [11:0] raw_data = '0;
  logic        force_zero;
  logic        out_valid;
  logic [11:0] out_data;

  always #2.5 clk = ~clk;

  ocf_top uut (
    .clk_i(clk), .rst_ni(rst_n), .soft_rst_i(soft_rst), .cal_start_i(cal_start),
    .fmt_bin_i(fmt_bin), .raw_valid_i(raw_valid), .raw_data_i(raw_data),
    .force_zero_o(force_zero), .out_valid_o(out_valid), .out_data_o(out_data)
  );

  typedef struct {
    logic [11:0] d;
    string       tag;
    int          cyc;
  } item_t;

  item_t       q[$];
  int          n_chk = 0;
  int          n_bad = 0;
  int          cyc = 0;
  logic [11:0] mdl_off = '0;
  bit          done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [11:0] model(logic [11:0] r, logic [11:0] o, logic b);
    int v;
    logic [11:0] t;
    v = int'($signed(r)) - int'($signed(o));
    if (v > 2047) v = 2047;
    if (v < -2048) v = -2048;
    t = v[11:0];
    if (b) t[11] = ~t[11];
    return t;
  endfunction

  task automatic chk(string tag, logic [11:0] act, logic [11:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pop and compare, verify one-cycle latency
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (q.size() == 0) begin
        chk("R7 unexpected out_valid", 12'(out_valid), 12'd0);
      end else begin
        item_t it;
        it = q.pop_front();
        chk(it.tag, out_data, it.d);
        chk({it.tag, " R7 latency"}, 12'(cyc - it.cyc), 12'd1);
      end
    end
  end

  task automatic send(logic [11:0] d, logic b, string tag);
    item_t it;
    raw_valid = 1'b1; raw_data = d; fmt_bin = b;
    it.d = model(d, mdl_off, b); it.tag = tag; it.cyc = cyc;
    q.push_back(it);
    @(posedge clk); #1;
    raw_valid = 1'b0;
  endtask

  task automatic calibrate(logic [11:0] v, bit repeat_start);
    cal_start = 1'b1;
    @(posedge clk); #1;
    cal_start = 1'b0;
    chk("R2 force_zero raised", 12'(force_zero), 12'd1);
    if (repeat_start) begin
      cal_start = 1'b1;
      @(posedge clk); #1;
      cal_start = 1'b0;
      chk("R9 repeat start keeps calibrating", 12'(force_zero), 12'd1);
    end
    raw_valid = 1'b1; raw_data = v;
    @(posedge clk); #1;
    raw_valid = 1'b0;
    mdl_off = v;
    chk("R3 force_zero released", 12'(force_zero), 12'd0);
    @(negedge clk);
    chk("R3 cal sample not output", 12'(out_valid), 12'd0);
    @(posedge clk); #1;
  endtask

  task automatic soft_clear(bit with_sample);
    soft_rst = 1'b1;
    if (with_sample) begin raw_valid = 1'b1; raw_data = 12'h055; end
    @(posedge clk); #1;
    soft_rst = 1'b0; raw_valid = 1'b0;
    mdl_off = '0;
    chk("R8 force_zero cleared", 12'(force_zero), 12'd0);
    @(negedge clk);
    chk("R8 no output on soft reset", 12'(out_valid), 12'd0);
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset out_valid", 12'(out_valid), 12'd0);
    chk("R1 reset force_zero", 12'(force_zero), 12'd0);
    rst_n = 1'b1;
    @(posedge clk); #1;

    send(12'h123, 1'b0, "R1 zero offset pass");
    send(12'h123, 1'b1, "R6 binary positive");
    send(12'hF00, 1'b1, "R6 binary negative");
    send(12'hF00, 1'b0, "R6 twos negative");

    calibrate(12'h010, 1'b0);
    send(12'h100, 1'b0, "R4 subtract offset");
    send(12'h000, 1'b0, "R4 zero minus offset");
    send(12'h800, 1'b0, "R5 saturate low");
    send(12'h800, 1'b1, "R5 saturate low binary");

    calibrate(12'hFFB, 1'b1);
    send(12'h7FF, 1'b0, "R5 saturate high");
    send(12'h7FF, 1'b1, "R5 saturate high binary");
    send(12'h000, 1'b0, "R4 negative offset");

    calibrate(12'h7FF, 1'b0);
    send(12'h800, 1'b0, "R5 extreme low");

    soft_clear(1'b1);
    send(12'h321, 1'b0, "R8 offset cleared");

    cal_start = 1'b1;
    @(posedge clk); #1;
    cal_start = 1'b0;
    chk("R2 second cal", 12'(force_zero), 12'd1);
    soft_clear(1'b0);
    send(12'h0AA, 1'b0, "R8 cal aborted, no capture");

    repeat (4) @(posedge clk);
    chk("R7 all outputs seen", 12'(q.size()), 12'd0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule